// File: doc/BRIEF.md
# Horizontal line timing generator

The block produces the horizontal timing of one video line from a single pixel clock, intended to run near 7 MHz with every downstream section on that same clock. A free-running position counter steps once per clock through 448 positions, 0 to 447, then starts the next line at 0. The top four bits of the position mark the boundaries of six fixed line segments at 32, 64, 96, 128 and 384. There is also a line-start boundary at 0.

Downstream logic receives a one-hot segment enable vector, so exactly one section of the line logic is active at any time. It also receives a one-clock boundary strobe at each segment start. Every output is taken from a flip-flop, so changes in the counter cannot glitch the enables. The decode works on the next position, which makes each registered enable and strobe line up with the registered position in the same cycle. A synchronous reset restarts the line at once.

Top module: `hline_timer`

## Requirements
- R1: `pos` increases by exactly one each clock. After 447 it returns to 0, so there are 448 clocks between line-start strobes and `pos` never exceeds 447.
- R2: A clock edge with `rst` high sets `pos` to 0, `seg_en` to 6'b000001 and `bnd_stb` to 6'b000001.
- R3: `seg_en` has exactly one bit set in every cycle after the first clock edge.
- R4: The set bit of `seg_en` follows `pos` in the same cycle. Bit 0 covers [0,32), bit 1 covers [32,64), bit 2 covers [64,96), bit 3 covers [96,128), bit 4 covers [128,384) and bit 5 covers [384,448).
- R5: `bnd_stb` bit k is high only in the cycle where `pos` equals the start of segment k: 0, 32, 64, 96, 128 or 384 for bits 0 to 5. At all other positions every bit is low.
- R6: Out of reset, `seg_en` changes only in a cycle in which `bnd_stb` is nonzero.
- R7: Asserting `rst` in the middle of a line restarts the count from 0. The line then runs on normally, with R1, R4 and R5 holding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pos | output | 9 | Registered horizontal position |
| seg_en | output | 6 | Registered one-hot segment enables |
| bnd_stb | output | 6 | Registered one-clock boundary strobes |

## Verification
The only input besides the clock is `rst`, and the assertions assume it is sampled synchronously and held high for at least one edge before the first checked cycle. The properties on cycle-to-cycle behaviour are switched off during reset and in the first cycle after it. The stimulus drives `rst` only on falling clock edges. It holds reset high from time zero through two edges, runs more than three complete lines, pulses reset once part-way through a line and then runs on. This covers the wrap from 447 to 0, every segment boundary and a restart in the middle of a segment.

// File: rtl/hline_pkg.sv
package hline_pkg;
  localparam int FIELD_W = 4;
  localparam int NSEG    = 6;
  localparam int NFIELD  = 1 << FIELD_W;

  // field code (upper position bits) at which line wraps
  localparam logic [FIELD_W-1:0] F_WRAP = 4'hE;

  // first and last field code covered by each segment
  localparam logic [FIELD_W-1:0] SEG_FIRST [NSEG] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hC};
  localparam logic [FIELD_W-1:0] SEG_LAST  [NSEG] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hB, 4'hD};

  typedef logic [NSEG-1:0] seg_vec_t;

  // mask of field codes belonging to segment k
  function automatic logic [NFIELD-1:0] seg_mask(input int k);
    logic [NFIELD-1:0] m;
    m = '0;
    for (int f = 0; f < NFIELD; f++)
      if (f >= int'(SEG_FIRST[k]) && f <= int'(SEG_LAST[k])) m[f] = 1'b1;
    return m;
  endfunction

  // next position with wrap taken from the field code
  function automatic logic [8:0] step_pos(input logic [8:0] p);
    logic [8:0] inc;
    inc = p + 9'd1;
    if (inc[8:5] == F_WRAP && inc[4:0] == 5'd0) inc = '0;
    return inc;
  endfunction
endpackage

// File: rtl/hline_counter.sv
module hline_counter
  import hline_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pos_q,
  output logic [CNT_W-1:0] pos_d
);
  localparam int LOW_W    = CNT_W - FIELD_W;
  localparam int LINE_LEN = int'(F_WRAP) << LOW_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_LEN - 1);

  logic [CNT_W-1:0] pos_inc;
  logic             wrap_hit;

  assign pos_inc  = pos_q + CNT_W'(1);
  assign wrap_hit = (pos_inc[CNT_W-1 -: FIELD_W] == F_WRAP) &&
                    (pos_inc[LOW_W-1:0] == '0);
  assign pos_d    = rst ? '0 : (wrap_hit ? '0 : pos_inc);

  always_ff @(posedge clk) pos_q <= pos_d;

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (pos_q != LAST) |=> (pos_q == $past(pos_q) + CNT_W'(1)));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (pos_q == LAST) |=> (pos_q == '0));
  assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);
endmodule

// File: rtl/hline_decode.sv
module hline_decode
  import hline_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] nxt,
  output seg_vec_t         seg_d,
  output seg_vec_t         stb_d
);
  localparam int LOW_W = CNT_W - FIELD_W;

  logic [NFIELD-1:0] fld_hot;
  logic              low_zero;

  assign low_zero = (nxt[LOW_W-1:0] == '0);

  // one-of-sixteen decode of the upper position bits
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign fld_hot[g] = (nxt[CNT_W-1 -: FIELD_W] == FIELD_W'(g));
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign seg_d[k] = |(fld_hot & seg_mask(k));
    assign stb_d[k] = fld_hot[SEG_FIRST[k]] & low_zero;
  end
endmodule

// File: rtl/hline_outreg.sv
module hline_outreg
  import hline_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  seg_vec_t seg_d,
  input  seg_vec_t stb_d,
  output seg_vec_t seg_q,
  output seg_vec_t stb_q
);
  localparam seg_vec_t FIRST_ONLY = seg_vec_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= FIRST_ONLY;
      stb_q <= FIRST_ONLY;
    end else begin
      seg_q <= seg_d;
      stb_q <= stb_d;
    end
  end

  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot(seg_q));
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && stb_q == '0) |-> $stable(seg_q));
  assert_stb_enables_R4: assert property (@(posedge clk) disable iff (rst)
    (stb_q != '0) |-> (stb_q == seg_q));
endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import hline_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pos,
  output logic [NSEG-1:0]  seg_en,
  output logic [NSEG-1:0]  bnd_stb
);
  localparam int LOW_W = CNT_W - FIELD_W;

  logic [CNT_W-1:0] pos_next;
  seg_vec_t         seg_next;
  seg_vec_t         stb_next;

  hline_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .pos_q(pos), .pos_d(pos_next)
  );

  hline_decode #(.CNT_W(CNT_W)) u_dec (
    .nxt(pos_next), .seg_d(seg_next), .stb_d(stb_next)
  );

  hline_outreg u_out (
    .clk(clk), .rst(rst), .seg_d(seg_next), .stb_d(stb_next),
    .seg_q(seg_en), .stb_q(bnd_stb)
  );

  assert_reset_R2: assert property (@(posedge clk)
    rst |=> (pos == '0 && seg_en == seg_vec_t'(1) && bnd_stb == seg_vec_t'(1)));

  for (genvar k = 0; k < NSEG; k++) begin : g_chk
    assert_stb_pos_R5: assert property (@(posedge clk) disable iff (rst)
      bnd_stb[k] |-> (pos[CNT_W-1 -: FIELD_W] == SEG_FIRST[k] && pos[LOW_W-1:0] == '0));
    assert_seg_range_R4: assert property (@(posedge clk) disable iff (rst)
      seg_en[k] |-> (pos[CNT_W-1 -: FIELD_W] >= SEG_FIRST[k] &&
                     pos[CNT_W-1 -: FIELD_W] <= SEG_LAST[k]));
  end
endmodule

// File: tb/hline_timer_tb.sv
module hline_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] pos;
  logic [5:0] seg_en;
  logic [5:0] bnd_stb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    int         p;
    logic [5:0] seg;
    logic [5:0] stb;
    bit         in_rst;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  hline_timer u_dut (.clk(clk), .rst(rst), .pos(pos), .seg_en(seg_en), .bnd_stb(bnd_stb));

  function automatic logic [5:0] ref_seg(input int p);
    if (p < 32)       return 6'b000001;
    else if (p < 64)  return 6'b000010;
    else if (p < 96)  return 6'b000100;
    else if (p < 128) return 6'b001000;
    else if (p < 384) return 6'b010000;
    else              return 6'b100000;
  endfunction

  function automatic logic [5:0] ref_stb(input int p);
    case (p)
      0:       return 6'b000001;
      32:      return 6'b000010;
      64:      return 6'b000100;
      96:      return 6'b001000;
      128:     return 6'b010000;
      384:     return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // driver: one expected item per clock edge
  int mpos = 0;
  int after_mid = 0;
  task automatic drive(input int n, input bit r, input bit mid);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      rst = r;
      if (r) begin
        mpos = 0;
        after_mid = mid ? 500 : 0;
      end else begin
        mpos = (mpos == 447) ? 0 : mpos + 1;
        if (after_mid > 0) after_mid--;
      end
      e.p = mpos; e.seg = ref_seg(mpos); e.stb = ref_stb(mpos); e.in_rst = r;
      e.tag = r ? "R2" : (after_mid > 0 ? "R7" : "R1");
      q.push_back(e);
    end
  endtask

  // monitor
  initial begin
    logic [5:0] prev_seg;
    int cyc = 0;
    int last_start = -1;
    bit have_prev = 0;
    forever begin
      @(posedge clk);
      #5;
      cyc++;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(pos == 9'(e.p), e.tag, int'(pos), e.p);
        check(seg_en == e.seg, e.in_rst ? "R2" : "R4", int'(seg_en), int'(e.seg));
        check(bnd_stb == e.stb, e.in_rst ? "R2" : "R5", int'(bnd_stb), int'(e.stb));
        check($countones(seg_en) == 1, "R3", $countones(seg_en), 1);
        if (have_prev && !e.in_rst && bnd_stb == 6'b0)
          check(seg_en == prev_seg, "R6", int'(seg_en), int'(prev_seg));
        if (e.in_rst) last_start = -1;
        else if (bnd_stb[0]) begin
          if (last_start >= 0) check(cyc - last_start == 448, "R1", cyc - last_start, 448);
          last_start = cyc;
        end
        prev_seg = seg_en;
        have_prev = 1;
      end
    end
  end

  initial begin
    drive(2, 1'b1, 1'b0);
    drive(3 * 448 + 100, 1'b0, 1'b0);
    drive(1, 1'b1, 1'b1);
    drive(1000, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
    end
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule